// File: doc/BRIEF.md
# Mask-Steered Bit Scatter/Gather Engine

This unit moves bits of a data word to new places under the control of a mask. In scatter mode, the lowest bits of the source are placed one by one into the positions where the mask holds a one. In gather mode, the source bits found at the mask's one-positions are collected and packed side by side from bit zero of the result upward. In both modes every result bit that receives no source bit reads zero.

The engine is iterative. A request is taken when `start_i` is high while the unit is idle. The unit then walks the set bits of the mask from the least significant upward. At each step it finds the lowest remaining set bit, moves one bit, and clears that mask bit. When no set bits remain, the unit presents the result with a one-cycle completion pulse. A request therefore costs one cycle for each set mask bit plus one closing cycle. The data width is a parameter; 32 and 64 are the intended values.

Top module: `bitperm_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy_o` and `done_o` are low and `result_o` is zero.
- R2: With `op_i` = 0 (scatter), the k-th lowest set bit of the mask, counting from k = 0, receives source bit k.
- R3: With `op_i` = 1 (gather), result bit k receives the source bit found at the k-th lowest set bit of the mask.
- R4: Result bits that receive nothing are zero. An all-zero mask gives a zero result, and `done_o` rises two cycles after the accepting edge.
- R5: If the accepting edge falls in cycle c and the mask has p set bits, `done_o` is high in cycle c+p+2. That is one step per set bit plus one closing cycle after the request registers.
- R6: `start_i` is ignored while `busy_o` is high. No extra completion occurs and the running result is unaffected.
- R7: `done_o` lasts exactly one cycle. `result_o` changes only in the cycle where `done_o` is high and holds its value until the next completion.
- R8: `op_i`, `src_i` and `mask_i` are captured on the accepting edge. Later changes to them during a run have no effect on that run.
- R9: `busy_o` is high from the cycle after a request is accepted until the completion cycle, where it is already low. A new request may be accepted in the same cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken when idle |
| op_i | input | 1 | 0 = scatter, 1 = gather |
| src_i | input | W | Source word |
| mask_i | input | W | Routing mask |
| busy_o | output | 1 | A request is being worked |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Registered result, held between completions |

## Verification
A completion pulse and the acceptance of the next request can share one cycle. This happens because `busy_o` has already dropped when `done_o` is high. The driver issues each new request at the first idle cycle, so every run after the first starts in the previous run's completion cycle, including runs with an all-zero mask. The scoreboard judges this overlap in two ways. Each popped item must match both the result and the exact completion cycle. `result_o` must also hold steady across the overlapping start until the next pulse.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

  typedef enum logic {
    PERM_SCATTER = 1'b0,
    PERM_GATHER  = 1'b1
  } perm_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } perm_state_e;

endpackage

// File: rtl/bitperm_lowbit.sv
// Finds the lowest set bit of a word and produces the word with it cleared.
module bitperm_lowbit #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (word_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o  = |word_i;
  assign rest_o = word_i & (word_i - W'(1));

endmodule

// File: rtl/bitperm_datapath.sv
// Holds the captured source and the result under construction; moves one bit per step.
module bitperm_datapath
  import bitperm_pkg::*;
#(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic          step_i,
  input  perm_op_e      op_i,
  input  logic [W-1:0]  src_i,
  input  logic [IW-1:0] pos_i,
  output logic [W-1:0]  acc_o
);

  logic [W-1:0]  src_q;
  logic [W-1:0]  acc_q;
  logic [IW-1:0] k_q;
  perm_op_e      op_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src_q <= '0;
      acc_q <= '0;
      k_q   <= '0;
      op_q  <= PERM_SCATTER;
    end else if (load_i) begin
      src_q <= src_i;
      acc_q <= '0;
      k_q   <= '0;
      op_q  <= op_i;
    end else if (step_i) begin
      if (op_q == PERM_SCATTER) acc_q[pos_i] <= src_q[k_q];
      else                      acc_q[k_q]   <= src_q[pos_i];
      k_q <= k_q + IW'(1);
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/bitperm_ctrl.sv
// Sequencer: accepts requests, walks the remaining mask, raises the completion pulse.
module bitperm_ctrl
  import bitperm_pkg::*;
#(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  acc_i,
  output logic          load_o,
  output logic          step_o,
  output logic [IW-1:0] pos_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  result_o
);

  perm_state_e  state_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] rem_next;
  logic         rem_any;
  logic         done_q;
  logic [W-1:0] result_q;

  bitperm_lowbit #(.W(W)) u_lowbit (
    .word_i (rem_q),
    .any_o  (rem_any),
    .idx_o  (pos_o),
    .rest_o (rem_next)
  );

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN) && rem_any;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_IDLE;
      rem_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rem_q   <= mask_i;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rem_any) begin
            rem_q <= rem_next;
          end else begin
            result_q <= acc_i;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/bitperm_unit.sv
// Top: iterative mask-steered scatter/gather engine.
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int IW = $clog2(W);

  logic          load;
  logic          step;
  logic [IW-1:0] pos;
  logic [W-1:0]  acc;

  bitperm_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .mask_i   (mask_i),
    .acc_i    (acc),
    .load_o   (load),
    .step_o   (step),
    .pos_o    (pos),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  bitperm_datapath #(.W(W)) u_dp (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .step_i (step),
    .op_i   (perm_op_e'(op_i)),
    .src_i  (src_i),
    .pos_i  (pos),
    .acc_o  (acc)
  );

endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         start_i,
  input logic [W-1:0] mask_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!busy_o && !done_o && result_o == '0));

  assert_zero_mask_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o && mask_i == '0) |=> ##1 (done_o && result_o == '0));

  assert_done_follows_run_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> $past(busy_o));

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> $stable(result_o));

  assert_idle_at_done_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> busy_o);

endmodule

bind bitperm_unit bitperm_unit_chk #(.W(W)) u_bitperm_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .start_i  (start_i),
  .mask_i   (mask_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_bitperm_unit.sv
`timescale 1ns/1ps
module test_bitperm_unit;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    int           cyc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] mask = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t sb[$];
  logic [W-1:0] last_res = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitperm_unit #(.W(W)) i_bitperm_unit (
    .clk_i(clk), .rst_i(rst), .start_i(start), .op_i(op),
    .src_i(src), .mask_i(mask), .busy_o(busy), .done_o(done), .result_o(result)
  );

  // Bit-serial reference: scan positions upward, count mask ones.
  function automatic logic [W-1:0] ref_perm(input logic g, input logic [W-1:0] s,
                                            input logic [W-1:0] m);
    logic [W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        if (!g) r[i] = s[k];
        else    r[k] = s[i];
        k++;
      end
    end
    return r;
  endfunction

  function automatic int ones(input logic [W-1:0] m);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue at first idle negedge, push expectation.
  task automatic issue(input logic g, input logic [W-1:0] s, input logic [W-1:0] m,
                       input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    start = 1'b1; op = g; src = s; mask = m;
    e.res = ref_perm(g, s, m);
    e.cyc = cyc + ones(m) + 2;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected completion actual=%h expected=none", result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, result, e.res);
          check({e.tag, " R5 latency"}, W'(cyc), W'(e.cyc));
        end
        last_res = result;
      end else if (result !== last_res) begin
        checks++; errors++;
        $display("FAIL R7 result moved without done actual=%h expected=%h", result, last_res);
        last_res = result;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog expired actual=hang expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", W'(busy), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", W'(busy), '0);
    check("R1 done", W'(done), '0);
    check("R1 result", result, '0);

    // Edge masks, both modes
    issue(1'b0, 32'h0000_00A5, 32'hFFFF_FFFF, "R2 scatter all-ones");
    issue(1'b1, 32'h1234_5678, 32'hFFFF_FFFF, "R3 gather all-ones");
    issue(1'b0, 32'h0000_0001, 32'h0001_0000, "R2 scatter single bit");
    issue(1'b1, 32'h8000_0000, 32'h8000_0000, "R3 gather single top bit");
    issue(1'b0, 32'h0000_FFFF, 32'h5555_5555, "R2 scatter alternating");
    issue(1'b1, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R3 gather alternating");
    issue(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, "R4 scatter zero mask");
    issue(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, "R4 gather zero mask");
    issue(1'b0, 32'hFFFF_0000, 32'h0F0F_0F0F, "R4 scatter unused bits zero");
    issue(1'b1, 32'hFFFF_FFFF, 32'h0000_F000, "R4 gather high bits zero");

    // R6 and R8: disturb inputs and start during a run
    issue(1'b1, 32'hDEAD_BEEF, 32'hF0F0_F0F0, "R6 R8 run under disturbance");
    op = 1'b0; src = 32'h0; mask = 32'hFFFF_FFFF;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    check("R9 busy during run", W'(busy), W'(1));

    for (int n = 0; n < 60; n++) begin
      issue(n[0], $urandom(), $urandom(), n[0] ? "R3 gather random" : "R2 scatter random");
    end
    for (int n = 0; n < 20; n++) begin
      issue(n[0], $urandom(), $urandom() & $urandom(), "R5 sparse random");
    end

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R7 done low when idle", W'(done), '0);
    finish_run();
  end

endmodule